// File: doc/BRIEF.md
# Row Hit Sub-Pattern Logger

This block sits beside one row of 48 pixel comparators and turns each sampled row snapshot into a short list of group-tagged sub-patterns. On a sample strobe (periodic or external trigger) it captures the hit flags together with the current time code, removes pixels disabled by a serially loaded mask, and splits the row into 8 groups of 6 neighbouring pixels. A group is logged only when at least two of its pixels are hit. Isolated single-pixel noise is dropped.

Each logged group becomes one 26-bit entry in a 19-deep circular register bank. The entry holds the time code, the group number and the group's 6-bit pattern. Entries drain one per clock in ascending group order after the capture. A downstream sequencer watches the empty flag, reads the entry at the head and pops it with a read strobe. When the bank is full, new entries are discarded and a sticky overflow flag records the loss.

Top module: `row_hit_logger`

## Requirements
- R1: After reset `empty_o` is 1, `overflow_o` is 0 and the mask is all zero, so every pixel is enabled.
- R2: On a clock edge where `sample_i` or `trig_i` is 1, the block captures `hits_i` and `time_i`. Group g covers flags 6g to 6g+5. A group qualifies when at least two of its unmasked flags are 1.
- R3: A qualifying entry that meets a full bank (19 entries held) is discarded. `overflow_o` then goes to 1 and stays at 1 until a cycle with `ovf_clr_i` at 1. If a discard and a clear fall in the same cycle, the discard wins.
- R4: The entry format is: bits 25:9 hold the captured time code, bits 8:6 hold the group number, and bits 5:0 hold the group's masked flags, with bit 0 being flag 6g.
- R5: Qualifying groups of one capture are written in ascending group order, one per clock. The first is written on the first edge after the capture edge.
- R6: While `mask_ld_i` is 1, each clock shifts `mask_sd_i` into mask bit 0 and moves every other mask bit up by one. A mask bit of 1 makes the matching flag count as 0.
- R7: `rd_data_o` shows the oldest held entry. A cycle with `rd_i` at 1 and a non-empty bank removes that entry. `rd_i` on an empty bank has no effect.
- R8: The bank behaves as a circular buffer of 19 entries. Entries keep first-in first-out order across pointer wrap.
- R9: A group with fewer than two unmasked hits is never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | Periodic sample strobe |
| trig_i | input | 1 | External trigger strobe |
| hits_i | input | 48 | Pixel hit flags |
| time_i | input | 17 | Current time code |
| mask_ld_i | input | 1 | Mask shift enable |
| mask_sd_i | input | 1 | Mask serial data |
| rd_i | input | 1 | Pop the head entry |
| ovf_clr_i | input | 1 | Clear the overflow flag |
| rd_data_o | output | 26 | Entry at the head of the bank |
| empty_o | output | 1 | Bank holds no entry |
| overflow_o | output | 1 | Sticky discard flag |

## Verification
The capture takes one edge, and the k-th qualifying group of that capture lands in the bank on the k-th edge after it. That entry, the empty flag and the overflow flag are therefore visible in the half cycle after that edge. A read or an overflow clear takes effect on the edge where it is sampled. The bench drives and compares on falling edges, so each result is checked in the half period after the edge that produced it. A behavioural queue model advances on the same rising edge and is compared on every falling edge. Directed checks count the same edges by hand for the timing and boundary cases.

// File: rtl/rhl_pkg.sv
package rhl_pkg;
  localparam int unsigned DEF_N_PIX  = 48;
  localparam int unsigned DEF_GRP_SZ = 6;
  localparam int unsigned DEF_TC_W   = 17;
  localparam int unsigned DEF_DEPTH  = 19;
endpackage

// File: rtl/rhl_mask_shift.sv
module rhl_mask_shift #(
  parameter int unsigned N_PIX = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic             sd_i,
  output logic [N_PIX-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= '0;
    else if (ld_i) mask_o <= {mask_o[N_PIX-2:0], sd_i};
  end
endmodule

// File: rtl/rhl_grouper.sv
module rhl_grouper #(
  parameter int unsigned N_PIX  = 48,
  parameter int unsigned GRP_SZ = 6,
  parameter int unsigned TC_W   = 17,
  localparam int unsigned N_GRP = N_PIX / GRP_SZ,
  localparam int unsigned ID_W  = $clog2(N_GRP),
  localparam int unsigned ENT_W = TC_W + ID_W + GRP_SZ
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic [N_PIX-1:0] hits_i,
  input  logic [N_PIX-1:0] mask_i,
  input  logic [TC_W-1:0]  time_i,
  output logic             wr_req_o,
  output logic [ENT_W-1:0] wr_ent_o
);
  logic [N_PIX-1:0] live;
  logic [N_PIX-1:0] pat_q;
  logic [TC_W-1:0]  tc_q;
  logic [N_GRP-1:0] qual, pend_q, pend_clr;
  logic [ID_W-1:0]  sel;

  assign live = hits_i & ~mask_i;

  for (genvar g = 0; g < N_GRP; g++) begin : g_qual
    assign qual[g] = ($countones(live[g*GRP_SZ +: GRP_SZ]) > 1);
  end

  // lowest pending group wins
  always_comb begin
    sel = '0;
    for (int i = N_GRP - 1; i >= 0; i--) begin
      if (pend_q[i]) sel = ID_W'(i);
    end
    pend_clr = '0;
    pend_clr[sel] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pat_q  <= '0;
      tc_q   <= '0;
      pend_q <= '0;
    end else if (strobe_i) begin
      pat_q  <= live;
      tc_q   <= time_i;
      pend_q <= qual;
    end else begin
      pend_q <= pend_q & ~pend_clr;
    end
  end

  assign wr_req_o = |pend_q;
  assign wr_ent_o = {tc_q, sel, pat_q[sel*GRP_SZ +: GRP_SZ]};
endmodule

// File: rtl/rhl_bank.sv
module rhl_bank #(
  parameter int unsigned ENT_W = 26,
  parameter int unsigned DEPTH = 19,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_req_i,
  input  logic [ENT_W-1:0] wr_data_i,
  input  logic             rd_i,
  input  logic             ovf_clr_i,
  output logic [ENT_W-1:0] rd_data_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             ovf_o,
  output logic             wr_en_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic             rd_en;

  assign empty_o = (cnt_o == '0);
  assign full_o  = (cnt_o == CNT_W'(DEPTH));
  assign wr_en_o = wr_req_i && !full_o;
  assign rd_en   = rd_i && !empty_o;
  assign rd_data_o = mem[rp_q];

  always_ff @(posedge clk_i) begin
    if (wr_en_o) mem[wp_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_o <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (wr_en_o) wp_q <= (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (rd_en)   rp_q <= (rp_q == PTR_W'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      if (wr_en_o && !rd_en)      cnt_o <= cnt_o + 1'b1;
      else if (!wr_en_o && rd_en) cnt_o <= cnt_o - 1'b1;
      if (wr_req_i && full_o) ovf_o <= 1'b1;
      else if (ovf_clr_i)     ovf_o <= 1'b0;
    end
  end
endmodule

// File: rtl/row_hit_logger.sv
module row_hit_logger #(
  parameter int unsigned N_PIX  = rhl_pkg::DEF_N_PIX,
  parameter int unsigned GRP_SZ = rhl_pkg::DEF_GRP_SZ,
  parameter int unsigned TC_W   = rhl_pkg::DEF_TC_W,
  parameter int unsigned DEPTH  = rhl_pkg::DEF_DEPTH,
  localparam int unsigned N_GRP = N_PIX / GRP_SZ,
  localparam int unsigned ID_W  = $clog2(N_GRP),
  localparam int unsigned ENT_W = TC_W + ID_W + GRP_SZ,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_i,
  input  logic             trig_i,
  input  logic [N_PIX-1:0] hits_i,
  input  logic [TC_W-1:0]  time_i,
  input  logic             mask_ld_i,
  input  logic             mask_sd_i,
  input  logic             rd_i,
  input  logic             ovf_clr_i,
  output logic [ENT_W-1:0] rd_data_o,
  output logic             empty_o,
  output logic             overflow_o
);
  logic [N_PIX-1:0]  mask;
  logic              strobe, wr_req, wr_en, full;
  logic [ENT_W-1:0]  wr_ent;
  logic [CNT_W-1:0]  cnt;
  logic [ID_W-1:0]   wr_id;
  logic [GRP_SZ-1:0] wr_pat;

  assign strobe = sample_i | trig_i;
  assign wr_id  = wr_ent[GRP_SZ +: ID_W];
  assign wr_pat = wr_ent[GRP_SZ-1:0];

  rhl_mask_shift #(.N_PIX(N_PIX)) u_mask (
    .clk_i, .rst_ni, .ld_i(mask_ld_i), .sd_i(mask_sd_i), .mask_o(mask)
  );

  rhl_grouper #(.N_PIX(N_PIX), .GRP_SZ(GRP_SZ), .TC_W(TC_W)) u_grp (
    .clk_i, .rst_ni, .strobe_i(strobe), .hits_i, .mask_i(mask),
    .time_i, .wr_req_o(wr_req), .wr_ent_o(wr_ent)
  );

  rhl_bank #(.ENT_W(ENT_W), .DEPTH(DEPTH)) u_bank (
    .clk_i, .rst_ni, .wr_req_i(wr_req), .wr_data_i(wr_ent), .rd_i,
    .ovf_clr_i, .rd_data_o, .empty_o, .full_o(full), .ovf_o(overflow_o),
    .wr_en_o(wr_en), .cnt_o(cnt)
  );
endmodule

// File: rtl/rhl_chk.sv
module rhl_chk #(
  parameter int unsigned ID_W   = 3,
  parameter int unsigned GRP_SZ = 6,
  parameter int unsigned DEPTH  = 19,
  parameter int unsigned CNT_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              strobe,
  input logic              wr_req,
  input logic              wr_en,
  input logic              full,
  input logic [ID_W-1:0]   wr_id,
  input logic [GRP_SZ-1:0] wr_pat,
  input logic [CNT_W-1:0]  cnt,
  input logic              ovf_clr_i,
  input logic              overflow_o,
  input logic              empty_o
);
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req && full |=> overflow_o);
  p_ovf_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o && !ovf_clr_i |=> overflow_o);
  p_asc_order_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en && $past(wr_en) && !$past(strobe) |-> wr_id > $past(wr_id));
  p_empty_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && !wr_en |=> empty_o);
  p_cnt_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CNT_W'(DEPTH));
  p_multi_hit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> $countones(wr_pat) > 1);
endmodule

bind row_hit_logger rhl_chk #(
  .ID_W(ID_W), .GRP_SZ(GRP_SZ), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .strobe(strobe), .wr_req(wr_req),
  .wr_en(wr_en), .full(full), .wr_id(wr_id), .wr_pat(wr_pat), .cnt(cnt),
  .ovf_clr_i(ovf_clr_i), .overflow_o(overflow_o), .empty_o(empty_o)
);

// File: tb/row_hit_logger_tb.sv
module row_hit_logger_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample = 1'b0, trig = 1'b0, mld = 1'b0, msd = 1'b0, rd = 1'b0, clr = 1'b0;
  logic [47:0] hits = '0;
  logic [16:0] tc = '0;
  logic [25:0] rdata;
  logic        empty, ovf;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  row_hit_logger u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .trig_i(trig),
    .hits_i(hits), .time_i(tc), .mask_ld_i(mld), .mask_sd_i(msd),
    .rd_i(rd), .ovf_clr_i(clr), .rd_data_o(rdata), .empty_o(empty),
    .overflow_o(ovf)
  );

  // behavioural reference
  logic [25:0] m_q[$];
  logic [25:0] m_pend[$];
  logic [47:0] m_mask;
  bit          m_ovf;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q.delete(); m_pend.delete(); m_mask = '0; m_ovf = 0;
    end else begin
      bit full_pre, drop;
      logic [25:0] e;
      logic [47:0] lv;
      full_pre = (m_q.size() == 19);
      drop = 0;
      if (rd && m_q.size() > 0) void'(m_q.pop_front());
      if (m_pend.size() > 0) begin
        e = m_pend.pop_front();
        if (!full_pre) m_q.push_back(e);
        else drop = 1;
      end
      if (clr) m_ovf = 0;
      if (drop) m_ovf = 1;
      if (sample || trig) begin
        m_pend.delete();
        lv = hits & ~m_mask;
        for (int g = 0; g < 8; g++) begin
          int n;
          n = 0;
          for (int b = 0; b < 6; b++) n += int'(lv[g*6+b]);
          if (n >= 2) m_pend.push_back({tc, 3'(g), lv[g*6 +: 6]});
        end
      end
      if (mld) m_mask = {m_mask[46:0], msd};
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(empty == (m_q.size() == 0), "R7 empty flag", 32'(empty), 32'(m_q.size() == 0));
      chk(ovf == m_ovf, "R3 overflow flag", 32'(ovf), 32'(m_ovf));
      if (m_q.size() > 0)
        chk(rdata === m_q[0], "R4 head entry", 32'(rdata), 32'(m_q[0]));
    end
  end

  task automatic strobe(logic [47:0] h, logic [16:0] t, bit use_trig);
    @(negedge clk);
    hits = h; tc = t;
    if (use_trig) trig = 1'b1; else sample = 1'b1;
    @(negedge clk);
    sample = 1'b0; trig = 1'b0; hits = '0;
  endtask

  task automatic pop();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(empty === 1'b1, "R1 empty after reset", 32'(empty), 1);
    chk(ovf === 1'b0, "R1 overflow after reset", 32'(ovf), 0);

    // R9: one hit per group never logged
    strobe(48'h041041041041, 17'h1, 0);
    repeat (3) @(negedge clk);
    chk(empty === 1'b1, "R9 single hits dropped", 32'(empty), 1);

    // R2 R5: groups 1 and 5 qualify
    strobe((48'h3 << 6) | (48'h7 << 30), 17'h1ABCD, 0);
    @(negedge clk);
    chk(rdata === {17'h1ABCD, 3'd1, 6'b000011}, "R5 first group", 32'(rdata),
        32'({17'h1ABCD, 3'd1, 6'b000011}));
    pop();
    chk(rdata === {17'h1ABCD, 3'd5, 6'b000111}, "R5 second group", 32'(rdata),
        32'({17'h1ABCD, 3'd5, 6'b000111}));
    pop();
    chk(empty === 1'b1, "R7 drained", 32'(empty), 1);
    pop();
    chk(empty === 1'b1, "R7 pop on empty ignored", 32'(empty), 1);

    // R2: external trigger, all groups full
    strobe('1, 17'h00042, 1);
    repeat (9) @(negedge clk);
    chk(rdata === {17'h00042, 3'd0, 6'h3F}, "R2 trigger capture", 32'(rdata),
        32'({17'h00042, 3'd0, 6'h3F}));
    repeat (8) pop();

    // R6: mask pixel 47 (first bit shifted ends up at bit 47)
    for (int i = 0; i < 48; i++) begin
      @(negedge clk); mld = 1'b1; msd = (i == 0);
    end
    @(negedge clk); mld = 1'b0; msd = 1'b0;
    strobe(48'h3 << 46, 17'h5, 0);
    repeat (2) @(negedge clk);
    chk(empty === 1'b1, "R6 masked pixel ignored", 32'(empty), 1);
    strobe(48'h3 << 45, 17'h6, 0);
    @(negedge clk);
    chk(rdata === {17'h6, 3'd7, 6'b011000}, "R6 unmasked pair logged", 32'(rdata),
        32'({17'h6, 3'd7, 6'b011000}));
    pop();

    // R8 R3: fill past capacity
    for (int i = 0; i < 21; i++) begin
      strobe(48'h3, 17'(100 + i), 0);
      @(negedge clk);
    end
    chk(ovf === 1'b1, "R3 overflow set", 32'(ovf), 1);
    @(negedge clk);
    chk(ovf === 1'b1, "R3 overflow sticky", 32'(ovf), 1);
    for (int i = 0; i < 19; i++) begin
      chk(rdata[25:9] === 17'(100 + i), "R8 fifo order", 32'(rdata[25:9]), 32'(100 + i));
      pop();
    end
    chk(empty === 1'b1, "R8 empty after 19 pops", 32'(empty), 1);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk(ovf === 1'b0, "R3 overflow cleared", 32'(ovf), 0);

    // R8: wrap and interleave
    for (int i = 0; i < 5; i++) begin
      strobe(48'hC00, 17'(200 + i), 0);
      @(negedge clk);
    end
    for (int i = 0; i < 5; i++) begin
      chk(rdata === {17'(200 + i), 3'd1, 6'b110000}, "R8 after wrap", 32'(rdata),
          32'({17'(200 + i), 3'd1, 6'b110000}));
      pop();
    end
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule